// File: doc/BRIEF.md
# Two-Line Instruction Fetch Cache

This block sits between a processor's instruction fetch port and a slow, word-wide backing memory. It keeps two single-word lines. Each line has a valid flag and a tag made of every word-address bit. A word from any address can therefore live in either line. A fetch compares its tag against both lines at once. When a line matches, the word comes back in the same cycle with no stall.

When neither line matches, the block holds the requester off and asks the backing memory for the aligned word. It waits for the memory's valid strobe, which arrives after a fixed latency of five cycles in the intended system. In the cycle the word arrives, the block passes it straight to the requester and also writes it into a line. An empty line is chosen first, lowest index first. When both lines are full, the line used longest ago is replaced. A single recency bit tracks this and is updated on every hit and every fill. Only one memory request is ever in flight, and no new fetch is accepted while a miss is being served.

Top module: `fetch_cache2`

## Requirements
- R1: After reset both lines are empty. With no fetch pending, fetch_ready and mem_req are low, and the first fetch of any address misses.
- R2: A fetch whose word-address tag matches a valid line has fetch_ready high in the same cycle as fetch_req. In that cycle fetch_data carries the stored word and mem_req stays low.
- R3: A fetch that matches no line has fetch_ready low and mem_req high in its first cycle. mem_addr equals the fetch address with bits [1:0] forced to zero.
- R4: In the cycle mem_valid is high while mem_req is high, fetch_ready is high and fetch_data equals mem_data. With a memory that answers in the fifth cycle of a request, a miss completes five cycles after the fetch begins.
- R5: The tag is address bits [31:2], and bits [1:0] play no part in a lookup. A fetch of 0x0E while the word at 0x0C is resident hits and returns the 0x0C word.
- R6: A fill goes to an empty line when one exists, line 0 before line 1. After two misses from reset, both filled words hit.
- R7: When both lines are valid, a miss replaces the line whose last hit or fill is older. For example, after 0x00 then 0x04 are used, a miss on 0x08 evicts 0x00, and a following miss on 0x0C evicts 0x04.
- R8: While a miss is outstanding, mem_req stays high with mem_addr unchanged, and fetch_ready stays low until mem_valid arrives.
- R9: A mem_valid pulse while mem_req is low has no effect. fetch_ready stays low, nothing is installed, and the next fetch of an unfilled address still misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request, held until fetch_ready |
| fetch_addr | input | 32 | Byte address of the instruction |
| fetch_ready | output | 1 | Fetch completes this cycle |
| fetch_data | output | 32 | Instruction word, valid with fetch_ready |
| mem_req | output | 1 | Backing memory read request |
| mem_addr | output | 32 | Word-aligned read address |
| mem_valid | input | 1 | Read data is valid this cycle |
| mem_data | input | 32 | Read data from backing memory |

## Verification
The assertions assume that the requester holds fetch_req and fetch_addr steady from the first cycle of a fetch until fetch_ready. They also assume the memory answers each request exactly once. The bench drives every fetch through a single task that keeps the request fixed until completion and drops it just after the accepting edge. Its memory model raises mem_valid only in the fifth cycle of a request. The stray strobe used for R9 is the one deliberate exception. It is sent while no request is pending, and no assertion depends on the memory staying quiet in that state.

// File: rtl/fc2_pkg.sv
package fc2_pkg;
  localparam int unsigned LINES = 2;
  localparam int unsigned IDX_W = 1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } fc2_state_t;
endpackage

// File: rtl/fc2_tag_store.sv
module fc2_tag_store
  import fc2_pkg::*;
#(
  parameter int unsigned TAG_W  = 30,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookup_en,
  input  logic [TAG_W-1:0]  lookup_tag,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  output logic [LINES-1:0]  hit_vec,
  output logic [DATA_W-1:0] hit_data,
  output logic [LINES-1:0]  valid_vec
);

  logic [DATA_W-1:0] rd_word [LINES];
  logic [TAG_W-1:0]  rd_tag  [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              v_q, v_d;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] d_q;
    logic              wr;

    assign wr = fill_en && (fill_idx == IDX_W'(i));

    always_comb begin
      v_d = v_q | wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (wr) begin
        t_q <= fill_tag;
        d_q <= fill_data;
      end
    end

    assign valid_vec[i] = v_q;
    assign hit_vec[i]   = lookup_en && v_q && (t_q == lookup_tag);
    assign rd_word[i]   = d_q;
    assign rd_tag[i]    = t_q;
  end

  always_comb begin
    hit_data = '0;
    for (int i = 0; i < LINES; i++) begin
      hit_data = hit_data | (rd_word[i] & {DATA_W{hit_vec[i]}});
    end
  end

  // R2: at most one line may match a lookup
  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R7: two valid lines never hold the same word
  p_unique_tags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid_vec) |-> (rd_tag[0] != rd_tag[1]));

  // R6: a filled line is valid from the next cycle
  p_fill_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_vec[$past(fill_idx)]);

endmodule

// File: rtl/fc2_lru.sv
module fc2_lru
  import fc2_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [LINES-1:0] valid_vec,
  output logic [IDX_W-1:0] victim_idx
);

  logic [IDX_W-1:0] old_q, old_d;

  always_comb begin
    old_d = old_q;
    if (touch_en) old_d = ~touch_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) old_q <= '0;
    else        old_q <= old_d;
  end

  always_comb begin
    if (!valid_vec[0])      victim_idx = 1'b0;
    else if (!valid_vec[1]) victim_idx = 1'b1;
    else                    victim_idx = old_q;
  end

  // R6: an empty line 0 is always picked first
  p_empty_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_vec[0] |-> (victim_idx == 1'b0));

  // R7: the most recently used line is never the victim when both are full
  p_recent_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (!(&valid_vec) || (victim_idx != $past(touch_idx))));

endmodule

// File: rtl/fc2_miss_fsm.sv
module fc2_miss_fsm
  import fc2_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              lookup_hit,
  input  logic              mem_valid,
  output logic              idle,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fill_en
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-OFS_W){1'b1}}, {OFS_W{1'b0}}};

  fc2_state_t        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  assign idle     = (st_q == ST_IDLE);
  assign mem_req  = (idle && fetch_req && !lookup_hit) || (st_q == ST_WAIT);
  assign mem_addr = idle ? (fetch_addr & ALIGN_MASK) : addr_q;
  assign fill_en  = mem_req && mem_valid;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (mem_req && !mem_valid) begin
          st_d    = ST_WAIT;
          addr_d  = fetch_addr & ALIGN_MASK;
          addr_en = 1'b1;
        end
      end
      ST_WAIT: begin
        if (mem_valid) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= addr_d;
  end

  // R8: an unanswered request persists with the same address
  p_hold_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R4: an answered request returns the controller to idle
  p_answer_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> idle);

  // R3: requests always carry a word-aligned address
  p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFS_W-1:0] == '0));

endmodule

// File: rtl/fetch_cache2.sv
module fetch_cache2
  import fc2_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic [DATA_W-1:0] fetch_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data
);

  localparam int unsigned OFS_W = $clog2(DATA_W / 8);
  localparam int unsigned TAG_W = ADDR_W - OFS_W;

  logic              idle;
  logic              lookup_en;
  logic [LINES-1:0]  hit_vec;
  logic              hit_any;
  logic [DATA_W-1:0] hit_data;
  logic [LINES-1:0]  valid_vec;
  logic              fill_en;
  logic [IDX_W-1:0]  victim_idx;
  logic              touch_en;
  logic [IDX_W-1:0]  touch_idx;

  assign lookup_en = idle && fetch_req;
  assign hit_any   = |hit_vec;

  fc2_tag_store #(
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .lookup_en  (lookup_en),
    .lookup_tag (fetch_addr[ADDR_W-1:OFS_W]),
    .fill_en    (fill_en),
    .fill_idx   (victim_idx),
    .fill_tag   (mem_addr[ADDR_W-1:OFS_W]),
    .fill_data  (mem_data),
    .hit_vec    (hit_vec),
    .hit_data   (hit_data),
    .valid_vec  (valid_vec)
  );

  fc2_miss_fsm #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .lookup_hit (hit_any),
    .mem_valid  (mem_valid),
    .idle       (idle),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .fill_en    (fill_en)
  );

  assign touch_en  = (lookup_en && hit_any) || fill_en;
  assign touch_idx = fill_en ? victim_idx : IDX_W'(hit_vec[1]);

  fc2_lru u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .valid_vec  (valid_vec),
    .victim_idx (victim_idx)
  );

  assign fetch_ready = (lookup_en && hit_any) || fill_en;
  assign fetch_data  = fill_en ? mem_data : hit_data;

  // R8: no completion while the memory has not answered
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |-> !fetch_ready);

  // R2: a hit never reaches the backing memory
  p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && |hit_vec) |-> !mem_req);

  // R9: a strobe without a request completes nothing
  p_stray_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_req && !fetch_req) |-> !fetch_ready);

endmodule

// File: tb/sim_fetch_cache2.sv
`timescale 1ns/1ps
module sim_fetch_cache2;
  localparam int MEM_LAT = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_req;
  logic [31:0] fetch_addr;
  logic        fetch_ready;
  logic [31:0] fetch_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid;
  logic [31:0] mem_data;
  logic        stray;

  int n_chk  = 0;
  int n_err  = 0;
  int n_hit  = 0;
  int n_miss = 0;
  int lat_cnt;

  always #10 clk = ~clk;

  fetch_cache2 u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr),
    .fetch_ready (fetch_ready),
    .fetch_data  (fetch_data),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_valid   (mem_valid),
    .mem_data    (mem_data)
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return 32'hA5C3_0000 ^ {a[15:0], a[15:0]} ^ 32'h0000_1111;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    lat_cnt <= 0;
    else if (mem_req && !mem_valid) lat_cnt <= lat_cnt + 1;
    else                           lat_cnt <= 0;
  end

  assign mem_valid = (mem_req && (lat_cnt == MEM_LAT - 1)) || stray;
  assign mem_data  = stray ? 32'hDEAD_BEEF : word_at(mem_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] a, input bit exp_hit, input string req);
    int cyc;
    logic [31:0] first_maddr;
    bit held_ok;
    @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = a;
    #1;
    cyc = 1;
    held_ok = 1'b1;
    first_maddr = mem_addr;
    if (mem_req) n_miss++; else n_hit++;
    chk(mem_req == !exp_hit, req, "memory request in first cycle", 32'(mem_req), 32'(!exp_hit));
    if (!exp_hit)
      chk(mem_addr == (a & 32'hFFFF_FFFC), "R3", "aligned request address", mem_addr, a & 32'hFFFF_FFFC);
    while (!fetch_ready && cyc < 20) begin
      @(negedge clk);
      #1;
      cyc++;
      if (!(mem_req && mem_addr == first_maddr)) held_ok = 1'b0;
    end
    if (!exp_hit) chk(held_ok, "R8", "request held steady during miss", 32'(held_ok), 32'd1);
    chk(cyc == (exp_hit ? 1 : MEM_LAT), exp_hit ? "R2" : "R4", "cycles to completion",
        32'(cyc), 32'(exp_hit ? 1 : MEM_LAT));
    chk(fetch_data == word_at(a & 32'hFFFF_FFFC), req, "returned word",
        fetch_data, word_at(a & 32'hFFFF_FFFC));
    @(posedge clk);
    #1;
    fetch_req = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(fetch_ready == 1'b0, "R1", "fetch_ready after reset", 32'(fetch_ready), 32'd0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'd0);
  endtask

  task automatic t_sequence;
    n_hit = 0; n_miss = 0;
    do_fetch(32'h00, 1'b0, "R1");
    do_fetch(32'h04, 1'b0, "R6");
    do_fetch(32'h00, 1'b1, "R6");
    do_fetch(32'h04, 1'b1, "R6");
    do_fetch(32'h08, 1'b0, "R7");
    do_fetch(32'h0C, 1'b0, "R7");
    chk(n_hit == 2, "R2", "hits in sequence", 32'(n_hit), 32'd2);
    chk(n_miss == 4, "R3", "misses in sequence", 32'(n_miss), 32'd4);
    do_fetch(32'h04, 1'b0, "R7");
  endtask

  task automatic t_offset;
    do_fetch(32'h08, 1'b0, "R7");
    do_fetch(32'h0E, 1'b0, "R5");
    do_fetch(32'h0E, 1'b1, "R5");
    do_fetch(32'h0D, 1'b1, "R5");
  endtask

  task automatic t_recency;
    do_fetch(32'h08, 1'b1, "R7");
    do_fetch(32'h10, 1'b0, "R7");
    do_fetch(32'h08, 1'b1, "R7");
    do_fetch(32'h0C, 1'b0, "R7");
  endtask

  task automatic t_stray;
    @(negedge clk);
    stray = 1'b1;
    #1;
    chk(fetch_ready == 1'b0, "R9", "ready on stray strobe", 32'(fetch_ready), 32'd0);
    @(negedge clk);
    stray = 1'b0;
    do_fetch(32'h14, 1'b0, "R9");
  endtask

  task automatic t_reset_clears;
    t_reset();
    do_fetch(32'h08, 1'b0, "R1");
    do_fetch(32'h08, 1'b1, "R2");
  endtask

  initial begin
    rst_n      = 1'b0;
    fetch_req  = 1'b0;
    fetch_addr = '0;
    stray      = 1'b0;
    t_reset();
    t_sequence();
    t_offset();
    t_recency();
    t_stray();
    t_reset_clears();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule